// File: doc/BRIEF.md
# I2C Word-Register Target

This block is an I2C target that fronts a bank of 16-bit registers selected by an 8-bit register pointer. It samples SCL and SDA with the system clock through two-flop synchronizers and detects START, repeated START and STOP on the synchronized lines. It drives SDA only as an open-drain enable and never holds SCL low.

A write transaction carries the device address with R/W low, then one pointer byte, then an optional data word sent as two bytes, most significant byte first. The block acknowledges each of these bytes. A write that stops right after the pointer byte only moves the pointer. A complete word reaches the register bank as one single-cycle strobe, and only after its low byte has been acknowledged.

A read transaction returns the register at the last stored pointer, high byte first. If the controller acknowledges the low byte and keeps clocking, the same register is sent again. The pointer survives any number of reads.

Top module: `i2c_word_target`

## Requirements
- R1: An address byte whose upper seven bits equal `dev_addr_i` is acknowledged, with bit 0 giving the direction (0 write, 1 read). Any other address gets no ACK, and every later byte is left unacknowledged until the next START.
- R2: In a write, the byte after the address is acknowledged and loaded into `ptr_o`.
- R3: The two data bytes after the pointer are both acknowledged. One cycle-long `wr_en_o` pulse then presents `{first byte, second byte}` on `wr_data_o`, with `ptr_o` unchanged. The pulse comes at the end of the second byte's ACK clock.
- R4: A write ended by STOP or repeated START right after the pointer byte updates `ptr_o` and produces no `wr_en_o`.
- R5: A write cut off after a single data byte produces no `wr_en_o`, so the register keeps its value.
- R6: A third data byte in the same write is not acknowledged and produces no further strobe.
- R7: A read returns `rd_data_i` for the current pointer, bits 15..8 first and then bits 7..0, each byte MSB first.
- R8: `ptr_o` keeps its value across read transactions until a later write loads a new pointer.
- R9: If the controller ACKs the low byte, the block sends the same register's word again from its high byte, and the pointer does not change.
- R10: A NACK from the controller, a STOP or a START ends a read. SDA is released, and the next transaction is served normally.
- R11: SDA is pulled low only in the block's own ACK slots and read-data bit slots. Its drive changes only after an SCL falling edge or a bus condition.
- R12: During and after reset, `sda_oe_o` and `wr_en_o` are low and `ptr_o` is 0.
- R13: A START seen at any point, even in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| dev_addr_i | input | 7 | Device address to match |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ptr_o | output | 8 | Current register pointer |
| wr_en_o | output | 1 | Single-cycle word write strobe |
| wr_data_o | output | 16 | Word to write |
| rd_data_i | input | 16 | Word of the register at `ptr_o` |

## Verification
The hardest state to reach from the ports is the end of a transaction at an unusual byte boundary. Examples are a write cut off after one data byte, a START arriving three bits into a byte, and a read that wraps back to the high byte after a controller ACK. The stimulus is a bit-level bus driver whose tasks can stop at any bit. The same driver then either issues a fresh START or keeps clocking with an ACK. A clock-by-clock model checks two things on every cycle: that SDA is only pulled low in the slots the model allows, and that every write strobe matches a queued expected word.

// File: rtl/i2c_wt_pkg.sv
package i2c_wt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_OUT, ST_TX, ST_ACK_IN, ST_SKIP
  } state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_PTR, PH_DATA, PH_OVER
  } phase_e;
endpackage

// File: rtl/i2c_wt_sync.sv
module i2c_wt_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_wt_bus_events.sv
module i2c_wt_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i && scl_d_q && sda_d_q && !sda_s_i;
  assign stop_o     = scl_s_i && scl_d_q && !sda_d_q && sda_s_i;
  assign scl_rise_o = scl_s_i && !scl_d_q;
  assign scl_fall_o = !scl_s_i && scl_d_q;

  // R13: bus events are mutually exclusive
  assert_event_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

// File: rtl/i2c_wt_engine.sv
module i2c_wt_engine
  import i2c_wt_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 2,
  localparam int ADDR_W    = BYTE_W - 1,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int CNT_W     = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BYTES - 1);

  state_e              state_q;
  phase_e              phase_q;
  logic [CNT_W-1:0]    bit_cnt_q;
  logic [BYTE_W-1:0]   rx_q, tx_q, ptr_q;
  logic [IDX_W-1:0]    idx_q;
  logic [WORD_W-1:0]   wacc_q, word_q;
  logic                rw_q, mack_q, wr_en_q;

  function automatic logic [BYTE_W-1:0] pick(input logic [WORD_W-1:0] w,
                                             input logic [IDX_W-1:0] idx);
    return w[(WORD_BYTES - 1 - int'(idx)) * BYTE_W +: BYTE_W];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      idx_q     <= '0;
      wacc_q    <= '0;
      word_q    <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i) begin
              rx_q      <= {rx_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == BIT_LAST) begin
              state_q <= ST_ACK_OUT;
              unique case (phase_q)
                PH_ADDR: begin
                  if (rx_q[BYTE_W-1:1] == dev_addr_i) rw_q <= rx_q[0];
                  else state_q <= ST_SKIP;
                end
                PH_PTR:  ptr_q  <= rx_q;
                PH_DATA: wacc_q <= {wacc_q[WORD_W-BYTE_W-1:0], rx_q};
                default: state_q <= ST_SKIP;
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              state_q   <= ST_RX;
              unique case (phase_q)
                PH_ADDR: begin
                  if (rw_q) begin
                    word_q  <= rd_data_i;
                    tx_q    <= pick(rd_data_i, '0);
                    idx_q   <= '0;
                    state_q <= ST_TX;
                  end else begin
                    phase_q <= PH_PTR;
                  end
                end
                PH_PTR: begin
                  phase_q <= PH_DATA;
                  idx_q   <= '0;
                end
                default: begin
                  if (idx_q == IDX_LAST) begin
                    wr_en_q <= 1'b1;
                    phase_q <= PH_OVER;
                  end else begin
                    idx_q <= idx_q + 1'b1;
                  end
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == BIT_LAST) state_q <= ST_ACK_IN;
              else tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
            end
          end
          ST_ACK_IN: begin
            if (scl_rise_i) begin
              mack_q <= !sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
                if (idx_q == IDX_LAST) begin
                  idx_q  <= '0;
                  word_q <= rd_data_i;
                  tx_q   <= pick(rd_data_i, '0);
                end else begin
                  idx_q <= idx_q + 1'b1;
                  tx_q  <= pick(word_q, idx_q + 1'b1);
                end
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = (state_q == ST_ACK_OUT) || (state_q == ST_TX && !tx_q[BYTE_W-1]);
  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wacc_q;

  assert_strobe_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  assert_strobe_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> $past(state_q) == ST_ACK_OUT);
  assert_sda_on_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall_i || start_i || stop_i));
  assert_ptr_hold_in_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX || state_q == ST_ACK_IN) |=> $stable(ptr_q));
  assert_skip_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && !start_i) |=> !sda_oe_o);
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target #(
  parameter int BYTE_W      = 8,
  parameter int WORD_BYTES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = BYTE_W - 1,
  localparam int WORD_W     = BYTE_W * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  logic [1:0] lines_s;
  logic start, stop, scl_rise, scl_fall;

  i2c_wt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_wt_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (lines_s[1]),
    .sda_s_i   (lines_s[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2c_wt_engine #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (lines_s[0]),
    .dev_addr_i(dev_addr_i),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr_o),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .rd_data_i (rd_data_i)
  );
endmodule

// File: tb/i2c_word_target_tb.sv
module i2c_word_target_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [6:0] dev_addr = 7'h40;
  logic sda_oe_o, wr_en_o;
  logic [7:0] ptr_o;
  logic [15:0] wr_data_o, rd_data;
  logic sda_line;

  logic [15:0] bank [256];
  logic [15:0] exp_bank [256];
  logic [23:0] exp_q [$];
  logic [7:0] mptr = 8'h00;
  bit oe_allowed = 1'b0;
  bit done = 1'b0;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe_o;
  assign rd_data  = bank[ptr_o];

  i2c_word_target u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .dev_addr_i(dev_addr),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr_o),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .rd_data_i (rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // external register bank
  always @(posedge clk) if (wr_en_o) bank[ptr_o] <= wr_data_o;

  // per-clock model comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sda_oe_o && !oe_allowed) chk("R11 sda driven outside slot", 1, 0);
      if (wr_en_o) begin
        if (exp_q.size() == 0) chk("R4/R5/R6 unexpected strobe (R4 R5 R6)", {8'h0, ptr_o, wr_data_o}, 0);
        else chk("R3 strobe word", {8'h0, ptr_o, wr_data_o}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit keep, output bit got);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; oe_allowed = exp_ack;
    wq(); scl_drv = 1'b1; wq(); got = !sda_line; wq(); scl_drv = 1'b0;
    if (!keep) begin wq(); oe_allowed = 1'b0; end
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    oe_allowed = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); d[i] = sda_line; wq(); scl_drv = 1'b0;
    end
    wq(); oe_allowed = 1'b0; sda_drv = !mack;
    scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0;
  endtask

  task automatic write_word(input logic [7:0] p, input logic [15:0] d);
    bit a;
    bus_start();
    send_byte({dev_addr, 1'b0}, 1, 0, a); chk("R1 address ack", a, 1);
    send_byte(p, 1, 0, a); chk("R2 pointer ack", a, 1);
    mptr = p;
    send_byte(d[15:8], 1, 0, a); chk("R3 msb ack", a, 1);
    exp_q.push_back({p, d});
    send_byte(d[7:0], 1, 0, a); chk("R3 lsb ack", a, 1);
    exp_bank[p] = d;
    bus_stop();
    chk("R2 ptr_o after write", ptr_o, p);
    chk("R3 strobe seen", exp_q.size(), 0);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a;
    bus_start();
    send_byte({dev_addr, 1'b0}, 1, 0, a); chk("R1 address ack", a, 1);
    send_byte(p, 1, 0, a); chk("R4 pointer ack", a, 1);
    mptr = p;
  endtask

  task automatic read_bytes(input int n, input bit start_first);
    bit a;
    logic [7:0] d;
    if (start_first) bus_start();
    send_byte({dev_addr, 1'b1}, 1, 1, a); chk("R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      if (k % 2 == 0) chk(k >= 2 ? "R9 repeat msb" : "R7 read msb", d, exp_bank[mptr][15:8]);
      else            chk(k >= 2 ? "R9 repeat lsb" : "R7 read lsb", d, exp_bank[mptr][7:0]);
    end
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) begin
      bank[i]     = 16'(i * 16'h0101) ^ 16'h5A3C;
      exp_bank[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    repeat (5) @(negedge clk);
    chk("R12 reset oe", sda_oe_o, 0);
    chk("R12 reset strobe", wr_en_o, 0);
    chk("R12 reset ptr", ptr_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 plain word write then R7 read
    write_word(8'h05, 16'hBEEF);
    read_bytes(2, 1); bus_stop();

    // R4 pointer-only write, then two reads keep pointer (R8)
    set_ptr(8'h12); bus_stop();
    chk("R4 ptr_o moved", ptr_o, 8'h12);
    read_bytes(2, 1); bus_stop();
    read_bytes(2, 1); bus_stop();
    chk("R8 ptr held after reads", ptr_o, 8'h12);

    // R9 controller ACKs low byte: word repeats
    read_bytes(5, 1); bus_stop();
    chk("R9 ptr unchanged", ptr_o, 8'h12);

    // R4 pointer set then repeated start into read
    set_ptr(8'h05);
    read_bytes(2, 1); bus_stop();

    // R10 read cut after msb by NACK, then new transaction
    read_bytes(1, 1); bus_stop();
    chk("R10 released after nack", sda_oe_o, 0);
    read_bytes(1, 1);
    set_ptr(8'h20); bus_stop();  // R10 read ended by repeated start
    chk("R10 write after start-ended read", ptr_o, 8'h20);

    // R5 one data byte then stop
    set_ptr(8'h30);
    send_byte(8'hAA, 1, 0, a); chk("R5 msb ack", a, 1);
    bus_stop();
    read_bytes(2, 1); bus_stop();

    // R6 extra byte after word
    set_ptr(8'h31);
    send_byte(8'h12, 1, 0, a);
    exp_q.push_back({8'h31, 16'h1234});
    send_byte(8'h34, 1, 0, a);
    exp_bank[8'h31] = 16'h1234;
    send_byte(8'h56, 0, 0, a); chk("R6 extra byte nack", a, 0);
    bus_stop();
    chk("R6 single strobe", exp_q.size(), 0);
    read_bytes(2, 1); bus_stop();

    // R1 wrong address ignored
    bus_start();
    send_byte({7'h41, 1'b0}, 0, 0, a); chk("R1 wrong address nack", a, 0);
    send_byte(8'h77, 0, 0, a); chk("R1 ignored byte nack", a, 0);
    send_byte(8'h99, 0, 0, a); chk("R1 ignored byte nack", a, 0);
    bus_stop();
    chk("R1 ptr untouched", ptr_o, mptr);

    // R13 start three bits into a byte restarts address phase
    bus_start();
    send_byte({dev_addr, 1'b0}, 1, 0, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    write_word(8'h44, 16'h0F0F);

    // R1 new device address
    dev_addr = 7'h2B;
    write_word(8'h7E, 16'hC3A5);
    read_bytes(2, 1); bus_stop();
    bus_start();
    send_byte({7'h40, 1'b1}, 0, 0, a); chk("R1 old address nack", a, 0);
    bus_stop();

    repeat (20) @(negedge clk);
    chk("R3 no pending strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule